// File: doc/BRIEF.md
# Keyed Configuration Access Port

This block is the configuration front door of a multi-function I/O device. A host reaches it through a two-byte window: offset 0 holds an index register and offset 1 is a data port that reads or writes whichever configuration register the index names. The space starts out sealed. Writing the key byte to the index port twice in a row opens it, and writing the lock byte to the index port seals it again. While the space is sealed, every read returns 0xFF and every data write is dropped.

With the space open, the host can read a fixed 16-bit manufacturer code and a parameterised 16-bit chip code. It can also choose one of several logical functions through a selector register. Each logical function owns a 16-bit relocatable I/O base, held in a bank of its own, and the selector decides which bank the base-address indices reach. The bus is a plain synchronous strobe interface. A read strobe returns its byte in the following cycle, marked by a one-cycle valid. A one-cycle pulse marks each transition from sealed to open.

Top module: `cfgport_top`

## Requirements
- R1: After reset the space is sealed, the selector holds LDN_RESET, every function's base holds BASE_RESET plus its function number times BASE_STRIDE, and bus_rvalid and unlock_pulse are low.
- R2: bus_addr 0 addresses the index register and bus_addr 1 the data port. A read strobe in cycle N gives bus_rvalid high with bus_rdata in cycle N+1, and bus_rvalid stays low in every other cycle.
- R3: Two consecutive index-port writes of 0x87, with no other write between them, open the space. unlock_pulse is high for exactly the cycle after the second write.
- R4: After a single 0x87, any other write returns the key tracker to its first stage. This covers an index write of another value and any data-port write. Another single 0x87 then leaves the space sealed.
- R5: While sealed, reads of either port return 0xFF, and data-port writes change no register.
- R6: While open, an index-port write of 0xAA seals the space and leaves the stored index unchanged. Any other index-port write while open, 0x87 included, is stored as the new index.
- R7: Index 0x20 reads the high byte and index 0x21 the low byte of CHIP_ID. Index 0x23 reads 0x19 and index 0x24 reads 0x34. Data writes to these four indices have no effect.
- R8: Index 0x07 is the read/write function selector.
- R9: Index 0x60 reads and writes the high byte of the selected function's base, and index 0x61 the low byte. Each function keeps its own value.
- R10: When the selector is NUM_LDEV or above, indices 0x60 and 0x61 read 0x00 and writes to them change nothing. Any index with no register behind it reads 0x00.
- R11: unlock_pulse fires only on a sealed-to-open transition. A 0x87 written while the space is already open raises no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High for one cycle after each read strobe |
| unlock_pulse | output | 1 | One-cycle pulse on each sealed-to-open transition |

## Verification
The hardest situation to reach from the ports is a key tracker left half-armed: one 0x87 accepted, then an interruption. The stimulus interrupts the key sequence twice, once with a foreign index value and once with a data-port write. After each interruption it writes a lone 0x87 and reads the data port, which must still return 0xFF. Writes made while sealed can only be seen after the space is reopened, so the bench writes the selector while sealed, reopens the space and reads the selector back. A behavioural model tracks the key stage, the index, the selector and every base, and it is compared with the outputs on every clock.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_BYTE    = 8'h87;
  localparam logic [7:0] LOCK_BYTE   = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CHIP_HI = 8'h20;
  localparam logic [7:0] IDX_CHIP_LO = 8'h21;
  localparam logic [7:0] IDX_MFG_HI  = 8'h23;
  localparam logic [7:0] IDX_MFG_LO  = 8'h24;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [15:0] MFG_CODE   = 16'h1934;
  localparam logic [7:0] SEALED_READ = 8'hFF;
endpackage

// File: rtl/cfgport_key_fsm.sv
module cfgport_key_fsm
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       is_open,
  output logic       open_pulse
);
  key_state_e state_q, state_d;
  logic       pulse_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KEY_IDLE: if (idx_wr && wdata == KEY_BYTE) state_d = KEY_HALF;
      KEY_HALF: begin
        if (idx_wr && wdata == KEY_BYTE) state_d = KEY_OPEN;
        else if (idx_wr || dat_wr)       state_d = KEY_IDLE;
      end
      KEY_OPEN: if (idx_wr && wdata == LOCK_BYTE) state_d = KEY_IDLE;
      default:  state_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_q != KEY_OPEN) && (state_d == KEY_OPEN);
    end
  end

  assign is_open    = (state_q == KEY_OPEN);
  assign open_pulse = pulse_q;
endmodule

// File: rtl/cfgport_global_regs.sv
module cfgport_global_regs
  import cfgport_pkg::*;
#(
  parameter logic [7:0]  LDN_RESET = 8'h00,
  parameter logic [15:0] CHIP_ID   = 16'h0541
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_open,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] idx_q,
  output logic [7:0] ldn_q,
  output logic       glb_hit,
  output logic [7:0] glb_rdata
);
  logic idx_load, ldn_load;

  assign idx_load = is_open && idx_wr && (wdata != LOCK_BYTE);
  assign ldn_load = is_open && dat_wr && (idx_q == IDX_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= LDN_RESET;
    end else begin
      if (idx_load) idx_q <= wdata;
      if (ldn_load) ldn_q <= wdata;
    end
  end

  always_comb begin
    glb_hit   = 1'b1;
    glb_rdata = 8'h00;
    unique case (idx_q)
      IDX_LDN:     glb_rdata = ldn_q;
      IDX_CHIP_HI: glb_rdata = CHIP_ID[15:8];
      IDX_CHIP_LO: glb_rdata = CHIP_ID[7:0];
      IDX_MFG_HI:  glb_rdata = MFG_CODE[15:8];
      IDX_MFG_LO:  glb_rdata = MFG_CODE[7:0];
      default:     glb_hit   = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfgport_ldev_bank.sv
module cfgport_ldev_bank
  import cfgport_pkg::*;
#(
  parameter int NUM_LDEV    = 8,
  parameter int BASE_RESET  = 'h0290,
  parameter int BASE_STRIDE = 'h0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] ldn,
  input  logic [7:0] wdata,
  output logic       bank_hit,
  output logic [7:0] bank_rdata
);
  localparam int SEL_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

  logic [15:0]      base_q [NUM_LDEV];
  logic             in_range;
  logic [SEL_W-1:0] sel;
  logic             hit_hi, hit_lo;
  logic [15:0]      cur_base;

  assign in_range = ({24'd0, ldn} < NUM_LDEV);
  assign sel      = ldn[SEL_W-1:0];
  assign hit_hi   = (idx == IDX_BASE_HI);
  assign hit_lo   = (idx == IDX_BASE_LO);
  assign bank_hit = hit_hi || hit_lo;

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_fn
    localparam logic [15:0] RST_VAL = 16'(BASE_RESET + g * BASE_STRIDE);
    logic mine;
    assign mine = wr_en && in_range && (int'(sel) == g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= RST_VAL;
      end else if (mine) begin
        if (hit_hi) base_q[g][15:8] <= wdata;
        if (hit_lo) base_q[g][7:0]  <= wdata;
      end
    end
  end

  always_comb begin
    cur_base = 16'h0000;
    for (int k = 0; k < NUM_LDEV; k++) begin
      if (in_range && int'(sel) == k) cur_base = base_q[k];
    end
  end

  assign bank_rdata = hit_hi ? cur_base[15:8] : (hit_lo ? cur_base[7:0] : 8'h00);
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int          NUM_LDEV    = 8,
  parameter logic [15:0] CHIP_ID     = 16'h0541,
  parameter logic [7:0]  LDN_RESET   = 8'h00,
  parameter int          BASE_RESET  = 'h0290,
  parameter int          BASE_STRIDE = 'h0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid,
  output logic       unlock_pulse
);
  logic       idx_wr, dat_wr, is_open;
  logic [7:0] idx_q, ldn_q;
  logic       glb_hit, bank_hit;
  logic [7:0] glb_rdata, bank_rdata;
  logic [7:0] rd_mux;
  logic [7:0] rdata_q;
  logic       rvalid_q;

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr && bus_addr;

  cfgport_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(bus_wdata), .is_open(is_open), .open_pulse(unlock_pulse)
  );

  cfgport_global_regs #(.LDN_RESET(LDN_RESET), .CHIP_ID(CHIP_ID)) u_glb (
    .clk(clk), .rst_n(rst_n), .is_open(is_open), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wdata(bus_wdata), .idx_q(idx_q), .ldn_q(ldn_q),
    .glb_hit(glb_hit), .glb_rdata(glb_rdata)
  );

  cfgport_ldev_bank #(
    .NUM_LDEV(NUM_LDEV), .BASE_RESET(BASE_RESET), .BASE_STRIDE(BASE_STRIDE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(is_open && dat_wr), .idx(idx_q),
    .ldn(ldn_q), .wdata(bus_wdata), .bank_hit(bank_hit), .bank_rdata(bank_rdata)
  );

  always_comb begin
    if (!is_open)      rd_mux = SEALED_READ;
    else if (!bus_addr) rd_mux = idx_q;
    else if (glb_hit)  rd_mux = glb_rdata;
    else if (bank_hit) rd_mux = bank_rdata;
    else               rd_mux = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       bus_rvalid,
  input logic       unlock_pulse,
  input logic       is_open,
  input logic [7:0] idx_q
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R2
  AST_PULSE_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87)); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |=> !unlock_pulse); // R11
  AST_SEALED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_open) |=> (bus_rdata == 8'hFF)); // R5
  AST_LOCK_BYTE_SEALS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !is_open); // R6
  AST_MFG_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr && is_open && idx_q == 8'h23) |=> (bus_rdata == 8'h19)); // R7
endmodule

bind cfgport_top cfgport_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .unlock_pulse(unlock_pulse),
  .is_open(is_open), .idx_q(idx_q)
);

// File: tb/cfgport_top_test.sv
module cfgport_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, unlock_pulse;

  always #2 clk = ~clk;

  cfgport_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .unlock_pulse(unlock_pulse)
  );

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int m_stage, m_idx, m_ldn;
  int m_base[8];
  int e_rdata, e_valid, e_pulse;

  function automatic int model_read(input int port);
    if (m_stage != 2) return 'hFF;
    if (port == 0) return m_idx;
    case (m_idx)
      'h07: return m_ldn;
      'h20: return 'h05;
      'h21: return 'h41;
      'h23: return 'h19;
      'h24: return 'h34;
      'h60: return (m_ldn < 8) ? (m_base[m_ldn] >> 8) : 0;
      'h61: return (m_ldn < 8) ? (m_base[m_ldn] & 'hFF) : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_idx = 0; m_ldn = 0;
      for (int i = 0; i < 8; i++) m_base[i] = 'h290 + i * 'h10;
      e_valid = 0; e_pulse = 0; e_rdata = 0;
    end else begin
      e_valid = bus_rd;
      if (bus_rd) e_rdata = model_read(bus_addr);
      e_pulse = 0;
      if (bus_wr && !bus_addr) begin
        if (m_stage == 0) begin
          if (bus_wdata == 8'h87) m_stage = 1;
        end else if (m_stage == 1) begin
          if (bus_wdata == 8'h87) begin m_stage = 2; e_pulse = 1; end
          else m_stage = 0;
        end else begin
          if (bus_wdata == 8'hAA) m_stage = 0;
          else m_idx = bus_wdata;
        end
      end else if (bus_wr && bus_addr) begin
        if (m_stage == 1) m_stage = 0;
        else if (m_stage == 2) begin
          if (m_idx == 'h07) m_ldn = bus_wdata;
          else if (m_idx == 'h60 && m_ldn < 8)
            m_base[m_ldn] = (m_base[m_ldn] & 'hFF) | (int'(bus_wdata) << 8);
          else if (m_idx == 'h61 && m_ldn < 8)
            m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | int'(bus_wdata);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (bus_rvalid !== e_valid[0]) begin
        mismatched++;
        $display("FAIL %s rvalid actual %0b expected %0d", cur_req, bus_rvalid, e_valid);
      end else if (e_valid != 0 && bus_rdata !== 8'(e_rdata)) begin
        mismatched++;
        $display("FAIL %s rdata actual %02h expected %02h", cur_req, bus_rdata, e_rdata);
      end
      if (unlock_pulse !== e_pulse[0]) begin
        mismatched++;
        $display("FAIL %s unlock_pulse actual %0b expected %0d", cur_req, unlock_pulse, e_pulse);
      end
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input bit a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic open_space();
    wr(0, 8'h87); wr(0, 8'h87);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state of the outputs
    compared++;
    if (bus_rvalid !== 1'b0 || unlock_pulse !== 1'b0 || bus_rdata !== 8'h00) begin
      mismatched++;
      $display("FAIL R1 reset outputs actual %0b/%0b/%02h expected 0/0/00",
               bus_rvalid, unlock_pulse, bus_rdata);
    end
    cur_req = "R5"; rd(0); rd(1); wr(1, 8'h55); rd(1);
    cur_req = "R4";
    wr(0, 8'h87); wr(0, 8'h20); wr(0, 8'h87); rd(1);
    wr(0, 8'h00);
    wr(0, 8'h87); wr(1, 8'h00); wr(0, 8'h87); rd(1); rd(0);
    wr(0, 8'h00);
    cur_req = "R3"; open_space(); @(negedge clk);
    cur_req = "R1"; wr(0, 8'h07); rd(1);
    for (int f = 0; f < 8; f++) begin
      wr(1, 8'(f)); wr(0, 8'h60); rd(1); wr(0, 8'h61); rd(1); wr(0, 8'h07);
    end
    cur_req = "R11"; wr(0, 8'h87); rd(0); wr(0, 8'h87); rd(0);
    cur_req = "R7";
    wr(0, 8'h20); rd(1); wr(1, 8'h12); rd(1);
    wr(0, 8'h21); rd(1);
    wr(0, 8'h23); rd(1); wr(1, 8'h00); rd(1);
    wr(0, 8'h24); rd(1);
    cur_req = "R8"; wr(0, 8'h07); wr(1, 8'h03); rd(1); wr(1, 8'hC4); rd(1);
    cur_req = "R9";
    wr(1, 8'h02); wr(0, 8'h60); wr(1, 8'hA5); wr(0, 8'h61); wr(1, 8'h5A); rd(1);
    wr(0, 8'h07); wr(1, 8'h05); wr(0, 8'h60); wr(1, 8'h3C); rd(1);
    for (int f = 0; f < 8; f++) begin
      wr(0, 8'h07); wr(1, 8'(f)); wr(0, 8'h60); rd(1); wr(0, 8'h61); rd(1);
    end
    cur_req = "R10";
    wr(0, 8'h07); wr(1, 8'h09); wr(0, 8'h60); rd(1); wr(1, 8'h77);
    wr(0, 8'h61); rd(1); wr(1, 8'h88);
    wr(0, 8'h07); wr(1, 8'h01); wr(0, 8'h60); rd(1); wr(0, 8'h61); rd(1);
    wr(0, 8'h30); rd(1); wr(0, 8'h5F); rd(1);
    cur_req = "R6";
    wr(0, 8'h07); wr(0, 8'hAA); rd(0); rd(1);
    cur_req = "R5"; wr(1, 8'h66); wr(0, 8'h60);
    cur_req = "R6"; open_space(); rd(0); rd(1);
    cur_req = "R2"; bus_rd = 1; bus_addr = 1; repeat (3) @(negedge clk); bus_rd = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL %s watchdog actual timeout expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule